// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block holds the 16-bit program counter and the 16-bit stack pointer of a small 8-bit processor core. It carries out every operation that changes the flow of control or moves a word to or from the stack. Those operations are direct jumps, calls and returns, each with a conditional form, the eight fixed-vector restarts, register-pair push and pop, loading PC or SP from the HL pair, and swapping HL with the word on top of the stack. A decoder outside the block supplies an operation code, a condition code, a 16-bit target, the HL pair, the pair to push and four status flags, then pulses `start`. Instruction fetch and decode are not part of this block.

Stack traffic uses a byte-wide memory port that makes at most one access per cycle. Read data is sampled one cycle after the read strobe. Stack words are stored little-end-low. A push therefore writes the high byte below SP first and the low byte below that. A pop reads the low byte at SP and then the high byte above it. `done` pulses for one cycle after the last register update of each operation. Operations that need no memory finish in a single cycle.

Top module: `pc_stack_seq`

## Requirements
- R1: After reset, PC and SP are both 0000h, `done` is low and neither memory strobe is active.
- R2: Op codes 0 (jump), 9 (PC from HL) and any unlisted code (12 to 15) finish in one cycle with no memory access. The new PC is the target, {H,L}, or PC+1 respectively, and `done` is high in the cycle after `start` is sampled.
- R3: The condition field selects the test as follows: 0 Z clear, 1 Z set, 2 carry clear, 3 carry set, 4 parity clear, 5 parity set, 6 sign clear, 7 sign set. Op 1 (conditional jump) loads the target when the test holds.
- R4: A conditional jump (op 1) or conditional call (op 3) whose test fails sets PC to PC+3. A conditional return (op 5) whose test fails sets PC to PC+1. In each case there is no memory access and `done` follows in one cycle.
- R5: Push (op 7) writes the high byte of `pair_in` at SP-1 and then the low byte at SP-2 in the next cycle. It leaves SP lowered by 2 and PC+1, and `done` is high in the third cycle after `start` is sampled.
- R6: Pop (op 8) reads SP (low byte) and then SP+1 (high byte). It presents the word on `pair_out`, leaves SP raised by 2 and PC+1, and `done` is high in the fourth cycle after `start` is sampled.
- R7: Call (op 2), and a conditional call (op 3) whose test holds, push PC+3 with the push byte order of R5 and then load PC with the target.
- R8: Return (op 4), and a conditional return (op 5) whose test holds, pop a word with the byte order of R6 into PC.
- R9: Restart (op 6) with condition field n pushes PC+1 and loads PC with n times 8, which gives 0000h to 0038h.
- R10: Op 10 copies HL into SP in one cycle and sets PC to PC+1.
- R11: Op 11 reads SP and SP+1, then writes L at SP and H at SP+1. SP does not change, the old stack word appears on `pair_out`, and PC becomes PC+1.
- R12: The read and write strobes are never high together.
- R13: A `start` pulse that arrives while an operation is in progress is ignored.
- R14: PC and SP arithmetic wraps modulo 2^16. For example, a push from SP 0000h writes FFFFh and then FFFEh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the operation on `op`; sampled only when idle |
| op | input | 4 | Operation code (see R2 to R11) |
| cc | input | 3 | Condition code, or restart number for op 6 |
| target | input | 16 | Jump or call destination |
| pair_in | input | 16 | Register pair to push |
| hl | input | 16 | Current HL pair |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_p | input | 1 | Parity flag (set for even) |
| flag_cy | input | 1 | Carry flag |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| pair_out | output | 16 | Word from the last pop or stack exchange |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong sequencer state shows up at the ports within the same cycle. The strobe, address or byte on the memory port differs from the expected access order, so a slipped step or a swapped byte order is caught on the first access it affects. A wrong stack pointer moves every later stack address. It is therefore visible on `sp` at once and on `mem_addr` at the next push or pop. A mis-evaluated condition changes `pc` one cycle after `start` and also removes or adds a whole stack sequence.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int LEN_SHORT = 1;
  localparam int LEN_LONG  = 3;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam logic [3:0] OP_JMP   = 4'd0;
  localparam logic [3:0] OP_JCOND = 4'd1;
  localparam logic [3:0] OP_CALL  = 4'd2;
  localparam logic [3:0] OP_CCOND = 4'd3;
  localparam logic [3:0] OP_RET   = 4'd4;
  localparam logic [3:0] OP_RCOND = 4'd5;
  localparam logic [3:0] OP_RST   = 4'd6;
  localparam logic [3:0] OP_PUSH  = 4'd7;
  localparam logic [3:0] OP_POP   = 4'd8;
  localparam logic [3:0] OP_PCHL  = 4'd9;
  localparam logic [3:0] OP_SPHL  = 4'd10;
  localparam logic [3:0] OP_XTHL  = 4'd11;

  typedef enum logic [3:0] {
    S_IDLE, S_WR_HI, S_WR_LO, S_RD_LO, S_RD_HI, S_RD_CAP,
    S_XR_LO, S_XR_HI, S_XW_LO, S_XW_HI
  } st_e;

  function automatic word_t wrap_add(word_t w, int delta);
    return word_t'(int'(w) + delta);
  endfunction

  function automatic logic cond_met(logic [2:0] code, logic s, logic z, logic p, logic cy);
    case (code)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !cy;
      3'd3: return cy;
      3'd4: return !p;
      3'd5: return p;
      3'd6: return !s;
      default: return s;
    endcase
  endfunction

  function automatic logic is_cond(logic [3:0] op);
    return (op == OP_JCOND) || (op == OP_CCOND) || (op == OP_RCOND);
  endfunction

  function automatic word_t rst_vec(logic [2:0] n, int step);
    return word_t'(int'(n) * step);
  endfunction

  function automatic st_e entry_state(logic [3:0] op, logic taken);
    case (op)
      OP_CALL, OP_RST, OP_PUSH: return S_WR_HI;
      OP_CCOND:                 return taken ? S_WR_HI : S_IDLE;
      OP_RET, OP_POP:           return S_RD_LO;
      OP_RCOND:                 return taken ? S_RD_LO : S_IDLE;
      OP_XTHL:                  return S_XR_LO;
      default:                  return S_IDLE;
    endcase
  endfunction

  function automatic word_t quick_pc(logic [3:0] op, logic taken, word_t pc_now,
                                     word_t tgt, word_t hl_now);
    case (op)
      OP_JMP:   return tgt;
      OP_JCOND: return taken ? tgt : wrap_add(pc_now, LEN_LONG);
      OP_CCOND: return wrap_add(pc_now, LEN_LONG);
      OP_PCHL:  return hl_now;
      default:  return wrap_add(pc_now, LEN_SHORT);
    endcase
  endfunction

endpackage

// File: rtl/pcs_cond.sv
module pcs_cond import pcs_pkg::*; (
  input  logic [3:0] op,
  input  logic [2:0] cc,
  input  logic       fl_s,
  input  logic       fl_z,
  input  logic       fl_p,
  input  logic       fl_cy,
  output logic       taken
);
  localparam int NCOND = 8;
  logic [NCOND-1:0] hit;

  for (genvar i = 0; i < NCOND; i++) begin : g_cc
    assign hit[i] = cond_met(3'(i), fl_s, fl_z, fl_p, fl_cy);
  end

  assign taken = is_cond(op) ? hit[cc] : 1'b1;
endmodule

// File: rtl/pcs_fsm.sv
module pcs_fsm import pcs_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] op,
  input  logic       taken,
  output st_e        st,
  output logic       accept,
  output logic       quick,
  output logic       fin
);
  st_e st_q, st_d, entry;

  assign entry  = entry_state(op, taken);
  assign accept = start && (st_q == S_IDLE);
  assign quick  = accept && (entry == S_IDLE);
  assign fin    = quick || (st_q == S_WR_LO) || (st_q == S_RD_CAP) || (st_q == S_XW_HI);
  assign st     = st_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:   if (accept) st_d = entry;
      S_WR_HI:  st_d = S_WR_LO;
      S_WR_LO:  st_d = S_IDLE;
      S_RD_LO:  st_d = S_RD_HI;
      S_RD_HI:  st_d = S_RD_CAP;
      S_RD_CAP: st_d = S_IDLE;
      S_XR_LO:  st_d = S_XR_HI;
      S_XR_HI:  st_d = S_XW_LO;
      S_XW_LO:  st_d = S_XW_HI;
      S_XW_HI:  st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  // R13
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WR_HI && start) |=> (st_q == S_WR_LO));
endmodule

// File: rtl/pcs_bus.sv
module pcs_bus import pcs_pkg::*; (
  input  st_e   st,
  input  word_t sp_now,
  input  word_t wd,
  input  word_t hl_now,
  output logic  rd,
  output logic  wr,
  output word_t addr,
  output byte_t wdata
);
  always_comb begin
    rd    = 1'b0;
    wr    = 1'b0;
    addr  = '0;
    wdata = '0;
    case (st)
      S_WR_HI: begin wr = 1'b1; addr = wrap_add(sp_now, -1); wdata = wd[WORD_W-1:BYTE_W]; end
      S_WR_LO: begin wr = 1'b1; addr = wrap_add(sp_now, -1); wdata = wd[BYTE_W-1:0]; end
      S_RD_LO, S_RD_HI: begin rd = 1'b1; addr = sp_now; end
      S_XR_LO: begin rd = 1'b1; addr = sp_now; end
      S_XR_HI: begin rd = 1'b1; addr = wrap_add(sp_now, 1); end
      S_XW_LO: begin wr = 1'b1; addr = sp_now; wdata = hl_now[BYTE_W-1:0]; end
      S_XW_HI: begin wr = 1'b1; addr = wrap_add(sp_now, 1); wdata = hl_now[WORD_W-1:BYTE_W]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq import pcs_pkg::*; #(
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter logic [15:0] RESET_SP = 16'h0000,
  parameter int          VEC_STEP = 8
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  op,
  input  logic [2:0]  cc,
  input  logic [15:0] target,
  input  logic [15:0] pair_in,
  input  logic [15:0] hl,
  input  logic        flag_s,
  input  logic        flag_z,
  input  logic        flag_p,
  input  logic        flag_cy,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic [15:0] pair_out,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        done
);
  word_t pc_q, sp_q, wd_q, tgt_q, hl_q, res_q;
  byte_t lo_q, hi_q;
  logic [3:0] op_q;
  logic done_q;

  logic taken, accept, quick, fin;
  st_e  st;
  logic ret_kind;

  pcs_cond u_cond (
    .op(op), .cc(cc), .fl_s(flag_s), .fl_z(flag_z), .fl_p(flag_p), .fl_cy(flag_cy),
    .taken(taken)
  );

  pcs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .taken(taken),
    .st(st), .accept(accept), .quick(quick), .fin(fin)
  );

  pcs_bus u_bus (
    .st(st), .sp_now(sp_q), .wd(wd_q), .hl_now(hl_q),
    .rd(mem_rd), .wr(mem_wr), .addr(mem_addr), .wdata(mem_wdata)
  );

  assign ret_kind = (op_q == OP_RET) || (op_q == OP_RCOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      sp_q   <= RESET_SP;
      wd_q   <= '0;
      tgt_q  <= '0;
      hl_q   <= '0;
      res_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      op_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (accept) begin
        op_q  <= op;
        hl_q  <= hl;
        tgt_q <= (op == OP_RST) ? rst_vec(cc, VEC_STEP) : target;
        wd_q  <= (op == OP_PUSH) ? pair_in :
                 (op == OP_RST)  ? wrap_add(pc_q, LEN_SHORT) : wrap_add(pc_q, LEN_LONG);
      end
      if (quick) begin
        pc_q <= quick_pc(op, taken, pc_q, target, hl);
        if (op == OP_SPHL) sp_q <= hl;
      end
      case (st)
        S_WR_HI: sp_q <= wrap_add(sp_q, -1);
        S_WR_LO: begin
          sp_q <= wrap_add(sp_q, -1);
          pc_q <= (op_q == OP_PUSH) ? wrap_add(pc_q, LEN_SHORT) : tgt_q;
        end
        S_RD_LO: sp_q <= wrap_add(sp_q, 1);
        S_RD_HI: begin
          sp_q <= wrap_add(sp_q, 1);
          lo_q <= mem_rdata;
        end
        S_RD_CAP: begin
          if (ret_kind) pc_q <= {mem_rdata, lo_q};
          else begin
            res_q <= {mem_rdata, lo_q};
            pc_q  <= wrap_add(pc_q, LEN_SHORT);
          end
        end
        S_XR_HI: lo_q <= mem_rdata;
        S_XW_LO: hi_q <= mem_rdata;
        S_XW_HI: begin
          res_q <= {hi_q, lo_q};
          pc_q  <= wrap_add(pc_q, LEN_SHORT);
        end
        default: ;
      endcase
    end
  end

  assign pc       = pc_q;
  assign sp       = sp_q;
  assign pair_out = res_q;
  assign done     = done_q;

  // R12
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R5
  push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR_HI) |=> (mem_wr && mem_addr == $past(mem_addr) - 16'd1));

  // R6
  pop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD_LO) |=> (mem_rd && mem_addr == $past(mem_addr) + 16'd1));

  // R11
  xch_sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && op_q == OP_XTHL) |=> $stable(sp_q));

  // R2
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quick |=> (done && !mem_rd && !mem_wr));
endmodule

// File: tb/pc_stack_seq_tb.sv
`timescale 1ns/1ps
module pc_stack_seq_tb;
  import pcs_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] op = '0;
  logic [2:0] cc = '0;
  logic [15:0] tgt = '0, pair = '0, hl = '0;
  logic fs = 1'b0, fz = 1'b0, fp = 1'b0, fcy = 1'b0;
  logic [7:0] rdata = '0;
  logic [15:0] pc, sp, pair_out, mem_addr;
  logic [7:0] mem_wdata;
  logic mem_rd, mem_wr, done;

  always #4 clk = ~clk;

  pc_stack_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cc(cc), .target(tgt),
    .pair_in(pair), .hl(hl), .flag_s(fs), .flag_z(fz), .flag_p(fp), .flag_cy(fcy),
    .mem_rdata(rdata), .pc(pc), .sp(sp), .pair_out(pair_out), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .done(done)
  );

  int checks = 0, errors = 0;
  string m_req = "R1";

  logic [7:0] mem [logic [15:0]];
  function automatic logic [7:0] mrd(logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // reference model state
  logic [15:0] m_pc = '0, m_sp = '0, m_res = '0;
  logic m_done = 1'b0, m_busy = 1'b0;
  logic [27:0] q [$];
  logic [27:0] e, x;
  logic [15:0] f_pc, f_sp, f_res;
  bit f_sp_en, f_res_en;
  logic pend = 1'b0;
  logic [15:0] pend_a = '0;

  function automatic bit ref_cond(int c);
    bit f;
    case (c / 2)
      0: f = fz;
      1: f = fcy;
      2: f = fp;
      default: f = fs;
    endcase
    return (c % 2 == 1) ? f : !f;
  endfunction

  function automatic logic [27:0] ent(bit r, bit w, logic [1:0] d, logic [15:0] a, logic [7:0] v);
    return {r, w, d, a, v};
  endfunction

  task automatic push_word(logic [15:0] w);
    logic [15:0] a1, a2;
    a1 = m_sp - 16'd1; a2 = m_sp - 16'd2;
    q.push_back(ent(0, 1, 2'b11, a1, w[15:8]));
    q.push_back(ent(0, 1, 2'b11, a2, w[7:0]));
  endtask

  task automatic pop_word(output logic [15:0] w);
    logic [15:0] a1;
    a1 = m_sp + 16'd1;
    w = {mrd(a1), mrd(m_sp)};
    q.push_back(ent(1, 0, 2'b01, m_sp, 8'h00));
    q.push_back(ent(1, 0, 2'b01, a1, 8'h00));
    q.push_back(ent(0, 0, 2'b00, 16'h0000, 8'h00));
  endtask

  task automatic build();
    logic [15:0] w, a1;
    bit tk;
    q.delete(); f_sp_en = 0; f_res_en = 0;
    tk = ref_cond(int'(cc));
    case (op)
      4'd0: begin f_pc = tgt; m_req = "R2"; end
      4'd1: begin f_pc = tk ? tgt : m_pc + 16'd3; m_req = "R3"; end
      4'd2, 4'd3: if (op == 4'd2 || tk) begin push_word(m_pc + 16'd3); f_pc = tgt; m_req = "R7"; end
                  else begin f_pc = m_pc + 16'd3; m_req = "R4"; end
      4'd4, 4'd5: if (op == 4'd4 || tk) begin pop_word(w); f_pc = w; m_req = "R8"; end
                  else begin f_pc = m_pc + 16'd1; m_req = "R4"; end
      4'd6: begin push_word(m_pc + 16'd1); f_pc = 16'(int'(cc) * 8); m_req = "R9"; end
      4'd7: begin push_word(pair); f_pc = m_pc + 16'd1; m_req = "R5"; end
      4'd8: begin pop_word(w); f_res = w; f_res_en = 1; f_pc = m_pc + 16'd1; m_req = "R6"; end
      4'd9: begin f_pc = hl; m_req = "R2"; end
      4'd10: begin f_sp = hl; f_sp_en = 1; f_pc = m_pc + 16'd1; m_req = "R10"; end
      4'd11: begin
        a1 = m_sp + 16'd1;
        f_res = {mrd(a1), mrd(m_sp)}; f_res_en = 1; f_pc = m_pc + 16'd1; m_req = "R11";
        q.push_back(ent(1, 0, 2'b00, m_sp, 8'h00));
        q.push_back(ent(1, 0, 2'b00, a1, 8'h00));
        q.push_back(ent(0, 1, 2'b00, m_sp, hl[7:0]));
        q.push_back(ent(0, 1, 2'b00, a1, hl[15:8]));
      end
      default: begin f_pc = m_pc + 16'd1; m_req = "R2"; end
    endcase
  endtask

  task automatic finish_op();
    m_pc = f_pc;
    if (f_sp_en) m_sp = f_sp;
    if (f_res_en) m_res = f_res;
    m_done = 1'b1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = '0; m_sp = '0; m_res = '0; m_done = 0; m_busy = 0; q.delete();
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        e = q.pop_front();
        if (e[25:24] == 2'b01) m_sp = m_sp + 16'd1;
        else if (e[25:24] == 2'b11) m_sp = m_sp - 16'd1;
        if (q.size() == 0) begin m_busy = 1'b0; finish_op(); end
      end else if (start) begin   // R13: model accepts only when idle
        build();
        if (q.size() == 0) finish_op();
        else m_busy = 1'b1;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %h exp %h", m_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      x = (m_busy && q.size() > 0) ? q[0] : 28'd0;
      chk("pc", 32'(pc), 32'(m_pc));
      chk("sp", 32'(sp), 32'(m_sp));
      chk("done", 32'(done), 32'(m_done));
      chk("mem_rd", 32'(mem_rd), 32'(x[27]));
      chk("mem_wr", 32'(mem_wr), 32'(x[26]));
      if (x[27] || x[26]) chk("mem_addr", 32'(mem_addr), 32'(x[23:8]));
      if (x[26]) chk("mem_wdata", 32'(mem_wdata), 32'(x[7:0]));
      chk("pair_out", 32'(pair_out), 32'(m_res));
      checks++;
      if (mem_rd && mem_wr) begin
        errors++;
        $display("FAIL R12 strobes act rd=1 wr=1 exp exclusive");
      end
      rdata = pend ? mrd(pend_a) : 8'h00;
      pend = mem_rd; pend_a = mem_addr;
      if (mem_wr) mem[mem_addr] = mem_wdata;
    end
  end

  task automatic run(logic [3:0] o, logic [2:0] c, logic [15:0] t, logic [15:0] p,
                     logic [15:0] h, logic [3:0] fl);
    @(posedge clk); #1;
    op = o; cc = c; tgt = t; pair = p; hl = h; {fs, fz, fp, fcy} = fl; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    while (m_busy) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);   // R1 reset values compared at these negedges
    run(OP_PUSH, 0, 16'h0, 16'h1234, 16'h0, 4'h0);   // R5, R14 wrap below 0000h
    run(OP_POP, 0, 16'h0, 16'h0, 16'h0, 4'h0);       // R6
    run(OP_SPHL, 0, 16'h0, 16'h0, 16'h2000, 4'h0);   // R10
    run(OP_CALL, 0, 16'h4000, 16'h0, 16'h0, 4'h0);   // R7
    run(OP_RET, 0, 16'h0, 16'h0, 16'h0, 4'h0);       // R8
    run(OP_JMP, 0, 16'h1230, 16'h0, 16'h0, 4'h0);    // R2
    for (int c = 0; c < 8; c++) begin                // R3 each code, both flag polarities
      run(OP_JCOND, 3'(c), 16'h3000 + 16'(c * 16), 16'h0, 16'h0, 4'h0);
      run(OP_JCOND, 3'(c), 16'h3800 + 16'(c * 16), 16'h0, 16'h0, 4'hF);
    end
    for (int c = 0; c < 8; c++) begin                // R4, R7, R8 conditional forms
      run(OP_CCOND, 3'(c), 16'h5000 + 16'(c), 16'h0, 16'h0, 4'h0);
      run(OP_RCOND, 3'(c), 16'h0, 16'h0, 16'h0, 4'h0);
      run(OP_CCOND, 3'(c), 16'h6000 + 16'(c), 16'h0, 16'h0, 4'hF);
      run(OP_RCOND, 3'(c), 16'h0, 16'h0, 16'h0, 4'hF);
    end
    for (int n = 0; n < 8; n++)                      // R9
      run(OP_RST, 3'(n), 16'h0, 16'h0, 16'h0, 4'h0);
    run(OP_PCHL, 0, 16'h0, 16'h0, 16'hBEEF, 4'h0);   // R2
    run(OP_XTHL, 0, 16'h0, 16'h0, 16'hA55A, 4'h0);   // R11
    run(OP_POP, 0, 16'h0, 16'h0, 16'h0, 4'h0);       // R11 swapped word now on stack
    // R13: second start during a push is ignored
    @(posedge clk); #1;
    op = OP_PUSH; pair = 16'h9ABC; start = 1'b1;
    @(posedge clk); #1;
    op = OP_JMP; tgt = 16'h7777;
    @(posedge clk); #1;
    start = 1'b0;
    while (m_busy) begin @(posedge clk); #1; end
    run(4'd15, 0, 16'h0, 16'h0, 16'h0, 4'h0);        // R2 unlisted code
    run(OP_JMP, 0, 16'hFFFF, 16'h0, 16'h0, 4'h0);
    run(OP_JCOND, 1, 16'h1111, 16'h0, 16'h0, 4'h0);  // R14 PC wraps to 0002h
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog act running exp finished", m_req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule